// File: doc/BRIEF.md
# Glitch-Free System Clock Source Selector

The block picks the system clock from three sources: a reference leg, an external bit clock, and the output of an on-chip PLL. The reference leg is the logical OR of a crystal input and a master clock input, so whichever of the two is unused must be held at 0. Two byte-wide registers set the choice. They are written through an address, data and write-strobe port clocked by the reference leg. After reset the reference leg drives the system clock.

A guard mode protects the chip when the PLL drops out of lock. While the guard is on and the PLL is chosen, a low lock indication sends the system clock back to the reference leg, whatever the registers say. When lock returns, the PLL is taken back. The lock input is synchronised into the reference domain before it is used.

Every change of source is break-before-make. The old leg's enable is cleared through a two-stage synchroniser on that leg's falling edge. Only when every other leg's synchroniser is empty does the new leg begin filling its own. This keeps runt pulses off the system clock.

Top module: `clksel_top`

## Requirements
- R1: While reset is asserted and right after it is released, the reference leg drives `sysClk` and `activeSrc` reads 0.
- R2: The register at address 0xC9 holds the source choice. Bit 0 = 1 bypasses the PLL. Bit 1 = 1 picks the bit clock while bypassed, and bit 1 = 0 picks the reference leg. Its reset value is 0x01.
- R3: Writing 0x00 to 0xC9 makes the PLL drive `sysClk`, and `activeSrc` reads 1 once the switch completes.
- R4: Writing 0x03 to 0xC9 makes the bit clock drive `sysClk`, with `activeSrc` = 2. Writing 0x01 returns the reference leg, with `activeSrc` = 0.
- R5: Bit 7 of the register at 0xC4 enables the guard mode. It resets to 0, and the other bits of that register are ignored. With the guard on, bypass clear and `pllLocked` low, the reference leg is used. When `pllLocked` returns high, the PLL is used again. With bypass set, the guard has no effect.
- R6: With the guard off, the level of `pllLocked` has no effect on the selection.
- R7: At most one leg is enabled at any time. During a switch, `activeSrc` passes through 3 (no leg enabled) and never jumps directly from one source code to another.
- R8: Once a switch has settled, `sysClk` equals the waveform of the selected source clock.
- R9: The reference leg is the OR of `mclkIn` and `xtalIn`. With `mclkIn` held at 0, a clock on `xtalIn` both drives `sysClk` and clocks the register port.
- R10: Writes to addresses other than 0xC4 and 0xC9 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclkIn | input | 1 | Master clock input, one half of the reference leg |
| xtalIn | input | 1 | Crystal clock input, the other half of the reference leg |
| bitClkIn | input | 1 | External bit clock source |
| pllClkIn | input | 1 | PLL output clock source |
| pllLocked | input | 1 | PLL lock indication, asynchronous |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, sampled on the reference leg |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| sysClk | output | 1 | Selected system clock |
| activeSrc | output | 2 | Enabled leg: 0 reference, 1 PLL, 2 bit clock, 3 none |

## Verification
The hardest condition to reach from the ports is the brief gap in which no leg is enabled. It lasts only a few edges of the two clocks involved, and it is the only evidence that break-before-make ordering happened. The bench runs the three sources at unrelated periods. It triggers a switch and then polls `activeSrc` every half nanosecond, at instants offset from every clock edge, so it sees the none code and can catch any direct jump between source codes. Lock-driven fallback is reached by toggling `pllLocked` while the PLL is chosen, first with the guard on and then with it off.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int NUM_LEGS    = 3;
  localparam int LEG_REF     = 0;
  localparam int LEG_PLL     = 1;
  localparam int LEG_BIT     = 2;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;

  localparam logic [ADDR_W-1:0] ADDR_GUARD  = 8'hC4;
  localparam logic [ADDR_W-1:0] ADDR_SOURCE = 8'hC9;
  localparam int GUARD_BIT   = 7;
  localparam int BYPASS_BIT  = 0;
  localparam int BITSEL_BIT  = 1;

  typedef enum logic [1:0] {
    SRC_REF  = 2'd0,
    SRC_PLL  = 2'd1,
    SRC_BIT  = 2'd2,
    SRC_NONE = 2'd3
  } srcCodeT;

  // Control-to-datapath strobes
  typedef struct packed {
    logic [NUM_LEGS-1:0] legWant;   // one-hot wanted leg
    logic                fallback;  // guard is forcing the reference leg
  } selStrobeT;
endpackage

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              refClk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pllLocked,
  output selStrobeT         strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic guardOn;
  logic bypassPll;
  logic pickBitClk;
  logic [SYNC_STAGES-1:0] lockSync;
  logic lockedRef;

  // Register file, written on the reference leg
  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n) begin
      guardOn    <= 1'b0;
      bypassPll  <= 1'b1;
      pickBitClk <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_GUARD) begin
        guardOn <= wrData[GUARD_BIT];
      end
      if (wrAddr == ADDR_SOURCE) begin
        bypassPll  <= wrData[BYPASS_BIT];
        pickBitClk <= wrData[BITSEL_BIT];
      end
    end
  end

  // Bring the asynchronous lock flag into the reference domain
  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n) begin
      lockSync <= '0;
    end else begin
      lockSync <= {lockSync[LAST-1:0], pllLocked};
    end
  end
  assign lockedRef = lockSync[LAST];

  // Selection policy
  always_comb begin
    strobes          = '0;
    strobes.fallback = !bypassPll && guardOn && !lockedRef;
    if (bypassPll) begin
      if (pickBitClk) strobes.legWant[LEG_BIT] = 1'b1;
      else            strobes.legWant[LEG_REF] = 1'b1;
    end else if (strobes.fallback) begin
      strobes.legWant[LEG_REF] = 1'b1;
    end else begin
      strobes.legWant[LEG_PLL] = 1'b1;
    end
  end
endmodule

// File: rtl/clksel_datapath.sv
module clksel_datapath
  import clksel_pkg::*;
#(
  parameter int LEGS        = NUM_LEGS,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_LEG   = LEG_REF
) (
  input  logic [LEGS-1:0] legClk,
  input  logic            rst_n,
  input  selStrobeT       strobes,
  output logic [LEGS-1:0] legEn,
  output logic            sysClk
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LEGS-1:0] legBusy;
  logic [LEGS-1:0] legGated;

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    localparam logic [LEGS-1:0] SELF = LEGS'(1) << g;
    localparam logic [SYNC_STAGES-1:0] RST_VAL = (g == RESET_LEG) ? '1 : '0;

    logic [SYNC_STAGES-1:0] syncQ;
    logic othersBusy;
    logic enReq;

    assign othersBusy = |(legBusy & ~SELF);
    assign enReq      = strobes.legWant[g] & ~othersBusy;

    // Enable pipeline on the falling edge of this leg's own clock
    always_ff @(negedge legClk[g] or negedge rst_n) begin
      if (!rst_n) begin
        syncQ <= RST_VAL;
      end else begin
        syncQ <= {syncQ[LAST-1:0], enReq};
      end
    end

    assign legBusy[g]  = |syncQ;
    assign legEn[g]    = syncQ[LAST];
    assign legGated[g] = legClk[g] & legEn[g];
  end

  assign sysClk = |legGated;
endmodule

// File: rtl/clksel_top.sv
module clksel_top
  import clksel_pkg::*;
(
  input  logic              mclkIn,
  input  logic              xtalIn,
  input  logic              bitClkIn,
  input  logic              pllClkIn,
  input  logic              pllLocked,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              sysClk,
  output logic [1:0]        activeSrc
);
  logic                refClk;
  logic [NUM_LEGS-1:0] legClk;
  logic [NUM_LEGS-1:0] legEn;
  selStrobeT           strobes;

  assign refClk          = mclkIn | xtalIn;
  assign legClk[LEG_REF] = refClk;
  assign legClk[LEG_PLL] = pllClkIn;
  assign legClk[LEG_BIT] = bitClkIn;

  clksel_ctrl #(.SYNC_STAGES(2)) ctrl_i (
    .refClk    (refClk),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .pllLocked (pllLocked),
    .strobes   (strobes)
  );

  clksel_datapath #(
    .LEGS        (NUM_LEGS),
    .SYNC_STAGES (2),
    .RESET_LEG   (LEG_REF)
  ) dp_i (
    .legClk  (legClk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .legEn   (legEn),
    .sysClk  (sysClk)
  );

  always_comb begin
    unique case (legEn)
      3'b001:  activeSrc = SRC_REF;
      3'b010:  activeSrc = SRC_PLL;
      3'b100:  activeSrc = SRC_BIT;
      default: activeSrc = SRC_NONE;
    endcase
  end
endmodule

// File: rtl/clksel_chk.sv
module clksel_chk
  import clksel_pkg::*;
(
  input logic                refClk,
  input logic                rst_n,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   wrAddr,
  input logic [DATA_W-1:0]   wrData,
  input selStrobeT           strobes,
  input logic [NUM_LEGS-1:0] legEn
);
  // R7
  legs_exclusive_chk: assert property (@(posedge refClk) disable iff (!rst_n)
    $onehot0(legEn));

  // R2
  want_onehot_chk: assert property (@(posedge refClk) disable iff (!rst_n)
    $onehot(strobes.legWant));

  // R5
  fallback_ref_chk: assert property (@(posedge refClk) disable iff (!rst_n)
    strobes.fallback |-> strobes.legWant[LEG_REF]);

  // R3
  pll_select_chk: assert property (@(posedge refClk) disable iff (!rst_n)
    (wrEn && wrAddr == ADDR_SOURCE && wrData == 8'h00)
      |=> (strobes.legWant[LEG_PLL] || strobes.fallback));

  // R4
  bit_select_chk: assert property (@(posedge refClk) disable iff (!rst_n)
    (wrEn && wrAddr == ADDR_SOURCE && wrData[1:0] == 2'b11)
      |=> strobes.legWant[LEG_BIT]);
endmodule

bind clksel_top clksel_chk chk_i (
  .refClk  (refClk),
  .rst_n   (rst_n),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .strobes (strobes),
  .legEn   (legEn)
);

// File: tb/clksel_top_tb_top.sv
`timescale 1ns/1ps
module clksel_top_tb_top;
  logic tbClk = 1'b0;
  logic pllClk = 1'b0;
  logic bitClk = 1'b0;
  logic useXtal = 1'b0;
  logic rst_n = 1'b0;
  logic pllLocked = 1'b1;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic sysClk;
  logic [1:0] activeSrc;
  logic mclkIn, xtalIn;

  int checks = 0;
  int failures = 0;

  always #5   tbClk  = ~tbClk;   // 100 MHz
  always #3.5 pllClk = ~pllClk;
  always #6.5 bitClk = ~bitClk;

  assign mclkIn = useXtal ? 1'b0 : tbClk;
  assign xtalIn = useXtal ? tbClk : 1'b0;

  clksel_top dut_i (
    .mclkIn    (mclkIn),
    .xtalIn    (xtalIn),
    .bitClkIn  (bitClk),
    .pllClkIn  (pllClk),
    .pllLocked (pllLocked),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .sysClk    (sysClk),
    .activeSrc (activeSrc)
  );

  // {addr, data, lock, expected activeSrc, requirement tag}
  localparam int NVEC = 12;
  localparam logic [22:0] VECS [NVEC] = '{
    {8'hC9, 8'h01, 1'b1, 2'd0, 4'd4},   // R4 reference
    {8'hC9, 8'h00, 1'b1, 2'd1, 4'd3},   // R3 PLL
    {8'hC9, 8'h03, 1'b1, 2'd2, 4'd4},   // R4 bit clock
    {8'hC9, 8'h00, 1'b0, 2'd1, 4'd6},   // R6 guard off, lock ignored
    {8'hC4, 8'h80, 1'b0, 2'd0, 4'd5},   // R5 fallback
    {8'hC4, 8'h80, 1'b1, 2'd1, 4'd5},   // R5 relock
    {8'hC9, 8'h03, 1'b0, 2'd2, 4'd5},   // R5 bypass set, guard no effect
    {8'hC5, 8'h00, 1'b0, 2'd2, 4'd10},  // R10 other address ignored
    {8'hC4, 8'h7F, 1'b0, 2'd2, 4'd5},   // R5 bit 7 clear disables guard
    {8'hC9, 8'h00, 1'b0, 2'd1, 4'd6},   // R6 unlocked PLL kept, guard off
    {8'hC4, 8'h80, 1'b0, 2'd0, 4'd5},   // R5 fallback again
    {8'hC9, 8'h01, 1'b1, 2'd0, 4'd2}    // R2 bypass to reference
  };

  task automatic check(input int tag, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  function automatic logic srcWave(input logic [1:0] sel);
    case (sel)
      2'd0: return tbClk;
      2'd1: return pllClk;
      2'd2: return bitClk;
      default: return 1'b0;
    endcase
  endfunction

  // R8: compare sysClk with the selected clock at instants away from all edges
  task automatic checkWave(input int tag, input logic [1:0] sel);
    int bad = 0;
    @(posedge tbClk);
    #1.25;
    for (int k = 0; k < 24; k++) begin
      if (sysClk !== srcWave(sel)) bad++;
      #1;
    end
    check(tag, bad, 0, "sysClk waveform mismatches");
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge tbClk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge tbClk);
    wrEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(posedge tbClk);
    #1.25;
    check(1, activeSrc, 0, "status during reset");
    @(negedge tbClk);
    rst_n = 1'b1;
    #0.25;
    check(1, activeSrc, 0, "status after reset");
    checkWave(1, 2'd0);

    // Table walk (R2 R3 R4 R5 R6 R8 R10)
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] a, d;
      logic l;
      logic [1:0] e;
      logic [3:0] t;
      {a, d, l, e, t} = VECS[v];
      pllLocked = l;
      writeReg(a, d);
      repeat (30) @(posedge tbClk);
      #1.25;
      check(int'(t), activeSrc, e, $sformatf("status vector %0d", v));
      checkWave(8, e);
    end

    // R7: break-before-make, reference to bit clock
    begin
      int sawNone = 0;
      int jumps = 0;
      logic [1:0] prev;
      writeReg(8'hC9, 8'h03);
      #0.25;
      prev = activeSrc;
      for (int k = 0; k < 400; k++) begin
        #0.5;
        if (activeSrc == 2'd3) sawNone = 1;
        if (activeSrc != prev && prev != 2'd3 && activeSrc != 2'd3) jumps++;
        prev = activeSrc;
      end
      check(7, sawNone, 1, "gap with no leg seen");
      check(7, jumps, 0, "direct source jumps");
      check(7, activeSrc, 2, "status after gap");
    end

    // R7: break-before-make, bit clock to PLL
    begin
      int sawNone = 0;
      int jumps = 0;
      logic [1:0] prev;
      pllLocked = 1'b1;
      writeReg(8'hC9, 8'h00);
      #0.25;
      prev = activeSrc;
      for (int k = 0; k < 400; k++) begin
        #0.5;
        if (activeSrc == 2'd3) sawNone = 1;
        if (activeSrc != prev && prev != 2'd3 && activeSrc != 2'd3) jumps++;
        prev = activeSrc;
      end
      check(7, sawNone, 1, "gap bit to PLL seen");
      check(7, jumps, 0, "direct jumps bit to PLL");
    end

    // R9: crystal input as reference leg
    writeReg(8'hC9, 8'h01);
    repeat (30) @(posedge tbClk);
    @(negedge tbClk);
    useXtal = 1'b1;
    repeat (4) @(posedge tbClk);
    #1.25;
    check(9, activeSrc, 0, "reference via crystal");
    checkWave(9, 2'd0);
    writeReg(8'hC9, 8'h00);
    repeat (30) @(posedge tbClk);
    #1.25;
    check(9, activeSrc, 1, "write clocked by crystal");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule